// File: doc/BRIEF.md
# Quadrature Position Counter with Modulus

This block turns two phase inputs from an incremental encoder into up and down counts. It keeps a position counter that runs around a window bounded below by an initial value and above by a modulus value. Alongside it sit a revolution counter and a signed position-difference counter. Two auxiliary pins serve either as an index and a home reference (decode mode) or as a preset and a count enable (count mode). Their active edge or level is selectable, and a software strobe can also reload the position.

The block also supports a single-phase mode: a rising edge on phase A counts, and phase B gives the direction. Further options are a reverse bit that inverts counting and also changes the reload source, and a one-shot option that freezes the position after its first wrap. The outputs are the three counters, a direction flag, and one-cycle event pulses. The counters and events change two clock edges after the input that caused them: one edge samples the input and the next updates the state. Configuration inputs are static levels and are applied combinationally at the update edge.

Top module: `qdec_poscnt`

## Requirements
- R1: After synchronous reset the position, revolution and difference counters read 0, the direction flag reads 1 and every event output is low.
- R2: In two-phase mode, with the phases written as {A,B}, the sequence 00→10→11→01→00 counts up and the opposite sequence counts down. Each change of exactly one phase gives exactly one count. The difference counter adds +1 or −1 per count, and results appear two clock edges after the input change.
- R3: A change of both phases in the same sample produces no count and a one-cycle `ev_both_o` pulse.
- R4: Counting up while the position equals the modulus value loads the initial value and pulses `ev_rollover_o`. Counting down while it equals the initial value loads the modulus value and pulses `ev_rollunder_o`.
- R5: `dir_o` holds 1 after an up count and 0 after a down count. `ev_dirchg_o` pulses when a count goes against the previous direction.
- R6: A reload happens on every cycle the software strobe is high. In decode mode it also happens on the selected index edge when index reload is enabled, and on the selected home edge when home reload is enabled. A reload takes the initial value when `reverse_i`=0 and the modulus value when `reverse_i`=1.
- R7: `idx_neg_i`=0 selects the rising index/preset edge and 1 selects the falling edge. `ev_index_o` pulses only on the selected edge, and the other edge has no effect.
- R8: `reverse_i`=1 inverts the direction of every count.
- R9: With `one_shot_i`=1 the position stops after a wrap. It resumes only after a reload. Difference counting and the direction flag continue while it is stopped.
- R10: With `rev_on_wrap_i`=0, a decode-mode index edge adds 1 to the revolution counter when `dir_o`=1 and subtracts 1 when `dir_o`=0. With `rev_on_wrap_i`=1 it adds 1 on roll-over and subtracts 1 on roll-under instead.
- R11: In count mode, counts are taken only while ENABLE (`home_i`) is at its active level: high when `home_neg_i`=0, low when `home_neg_i`=1. `ev_home_o` pulses on any ENABLE change. In decode mode it pulses on the selected home edge.
- R12: In count mode the selected preset edge reloads the position and clears the revolution counter, whatever the index-reload enable says.
- R13: In single-phase mode a rising A edge is one count: up when B=0, down when B=1. A falling A edge and B changes do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pha_i | input | 1 | Phase A (filtered) |
| phb_i | input | 1 | Phase B (filtered) |
| idx_i | input | 1 | Index (decode mode) / preset (count mode) |
| home_i | input | 1 | Home (decode mode) / enable (count mode) |
| swinit_i | input | 1 | Software reload strobe, active each cycle high |
| cnt_mode_i | input | 1 | 0 decode mode, 1 count mode |
| idx_neg_i | input | 1 | Index/preset edge: 0 rising, 1 falling |
| home_neg_i | input | 1 | Home edge (0 rising, 1 falling) or enable level (0 high, 1 low) |
| idx_init_en_i | input | 1 | Index edge reloads position (decode mode) |
| home_init_en_i | input | 1 | Home edge reloads position (decode mode) |
| reverse_i | input | 1 | Invert counting, reload from modulus value |
| single_ph_i | input | 1 | Single-phase count mode |
| one_shot_i | input | 1 | Stop position after a wrap |
| rev_on_wrap_i | input | 1 | Revolution counter steps on wraps instead of index |
| init_val_i | input | POS_W | Initial (lower) value of the window |
| mod_val_i | input | POS_W | Modulus (upper) value of the window |
| pos_o | output | POS_W | Position counter |
| rev_o | output | REV_W | Revolution counter |
| diff_o | output | DIFF_W | Position-difference counter |
| dir_o | output | 1 | Direction of the most recent count, 1 up |
| ev_rollover_o | output | 1 | Roll-over pulse |
| ev_rollunder_o | output | 1 | Roll-under pulse |
| ev_index_o | output | 1 | Selected index/preset edge pulse |
| ev_home_o | output | 1 | Home edge / enable change pulse |
| ev_dirchg_o | output | 1 | Direction change pulse |
| ev_both_o | output | 1 | Simultaneous phase change pulse |

## Verification
The bench drives the window edges in both directions, because a design with an off-by-one compare would step to modulus+1 or init−1 instead of wrapping. It checks that a two-phase jump produces no count, which catches a decoder that guesses a direction. It reloads with reverse set, which exposes a design that always reloads from the initial value. It counts past a one-shot wrap, where a design that forgot the stop would keep moving, and it toggles ENABLE and its polarity in count mode, where a design that misread the level would count while disabled. It also checks that the unselected index edge, and a preset arriving while index reload is disabled, do what their requirements say, and that single-phase mode ignores falling A edges.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // One decoded count request: cnt says a count happens, up gives its direction.
  typedef struct packed {
    logic cnt;
    logic up;
  } qstep_t;

  // Edge detector with selectable polarity on a sampled pair.
  function automatic logic edge_sel(input logic cur, input logic prev, input logic neg);
    return neg ? (prev & ~cur) : (cur & ~prev);
  endfunction

endpackage

// File: rtl/qdec_sampler.sv
module qdec_sampler #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        cur[i]  <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        cur[i]  <= din[i];
        prev[i] <= cur[i];
      end
    end
  end

endmodule

// File: rtl/qdec_phase.sv
module qdec_phase
  import qdec_pkg::*;
(
  input  logic   a_cur,
  input  logic   b_cur,
  input  logic   a_prev,
  input  logic   b_prev,
  input  logic   single_ph,
  input  logic   reverse,
  output qstep_t step,
  output logic   both_chg
);

  logic chg_a, chg_b;
  logic raw_cnt, raw_up;

  always_comb begin
    chg_a    = a_cur ^ a_prev;
    chg_b    = b_cur ^ b_prev;
    both_chg = chg_a & chg_b;
    if (single_ph) begin
      raw_cnt = a_cur & ~a_prev;
      raw_up  = ~b_cur;
    end else begin
      raw_cnt = chg_a ^ chg_b;
      raw_up  = a_cur ^ b_prev;
    end
    step.cnt = raw_cnt;
    step.up  = raw_up ^ reverse;
  end

endmodule

// File: rtl/qdec_modcnt.sv
module qdec_modcnt
  import qdec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  qstep_t       step,
  input  logic         run,
  input  logic         init_req,
  input  logic         reverse,
  input  logic         one_shot,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] mod_val,
  output logic [W-1:0] pos,
  output logic         ov_nx,
  output logic         un_nx
);

  logic halted;
  logic at_top, at_bot, go;

  always_comb begin
    at_top = (pos == mod_val);
    at_bot = (pos == init_val);
    go     = step.cnt & run & ~(halted & one_shot);
    ov_nx  = ~init_req & go &  step.up & at_top;
    un_nx  = ~init_req & go & ~step.up & at_bot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      halted <= 1'b0;
    end else if (init_req) begin
      pos    <= reverse ? mod_val : init_val;
      halted <= 1'b0;
    end else if (go) begin
      if (step.up) pos <= at_top ? init_val : pos + 1'b1;
      else         pos <= at_bot ? mod_val  : pos - 1'b1;
      if (ov_nx || un_nx) halted <= one_shot;
    end
  end

endmodule

// File: rtl/qdec_updown.sv
module qdec_updown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i)          cnt_o <= '0;
    else if (inc_i && !dec_i)  cnt_o <= cnt_o + 1'b1;
    else if (dec_i && !inc_i)  cnt_o <= cnt_o - 1'b1;
  end

endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt
  import qdec_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int REV_W  = 16,
  parameter int DIFF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pha_i,
  input  logic              phb_i,
  input  logic              idx_i,
  input  logic              home_i,
  input  logic              swinit_i,
  input  logic              cnt_mode_i,
  input  logic              idx_neg_i,
  input  logic              home_neg_i,
  input  logic              idx_init_en_i,
  input  logic              home_init_en_i,
  input  logic              reverse_i,
  input  logic              single_ph_i,
  input  logic              one_shot_i,
  input  logic              rev_on_wrap_i,
  input  logic [POS_W-1:0]  init_val_i,
  input  logic [POS_W-1:0]  mod_val_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [REV_W-1:0]  rev_o,
  output logic [DIFF_W-1:0] diff_o,
  output logic              dir_o,
  output logic              ev_rollover_o,
  output logic              ev_rollunder_o,
  output logic              ev_index_o,
  output logic              ev_home_o,
  output logic              ev_dirchg_o,
  output logic              ev_both_o
);

  localparam int NS = 4;
  localparam int SA = 0;
  localparam int SB = 1;
  localparam int SI = 2;
  localparam int SH = 3;

  logic [NS-1:0] s_cur, s_prev;
  logic          sw_q;
  qstep_t        step;
  logic          both_chg;
  logic          idx_edge, home_edge, home_chg, en_ok, run, cnt_go, init_req;
  logic          ov_nx, un_nx;
  logic          rev_inc, rev_dec, rev_clr;
  logic          dir_q;

  qdec_sampler #(.N(NS)) u_samp (
    .clk  (clk),
    .rst  (rst),
    .din  ({home_i, idx_i, phb_i, pha_i}),
    .cur  (s_cur),
    .prev (s_prev)
  );

  always_ff @(posedge clk) begin
    if (rst) sw_q <= 1'b0;
    else     sw_q <= swinit_i;
  end

  qdec_phase u_phase (
    .a_cur     (s_cur[SA]),
    .b_cur     (s_cur[SB]),
    .a_prev    (s_prev[SA]),
    .b_prev    (s_prev[SB]),
    .single_ph (single_ph_i),
    .reverse   (reverse_i),
    .step      (step),
    .both_chg  (both_chg)
  );

  always_comb begin
    idx_edge  = edge_sel(s_cur[SI], s_prev[SI], idx_neg_i);
    home_edge = edge_sel(s_cur[SH], s_prev[SH], home_neg_i);
    home_chg  = s_cur[SH] ^ s_prev[SH];
    en_ok     = s_cur[SH] ^ home_neg_i;
    run       = ~cnt_mode_i | en_ok;
    cnt_go    = step.cnt & run;
    init_req  = sw_q | (cnt_mode_i ? idx_edge
                                   : ((idx_edge & idx_init_en_i) | (home_edge & home_init_en_i)));
    rev_clr   = cnt_mode_i & idx_edge;
    rev_inc   = rev_on_wrap_i ? ov_nx : (~cnt_mode_i & idx_edge &  dir_q);
    rev_dec   = rev_on_wrap_i ? un_nx : (~cnt_mode_i & idx_edge & ~dir_q);
  end

  qdec_modcnt #(.W(POS_W)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .run      (run),
    .init_req (init_req),
    .reverse  (reverse_i),
    .one_shot (one_shot_i),
    .init_val (init_val_i),
    .mod_val  (mod_val_i),
    .pos      (pos_o),
    .ov_nx    (ov_nx),
    .un_nx    (un_nx)
  );

  qdec_updown #(.W(REV_W)) u_rev (
    .clk   (clk),
    .rst   (rst),
    .clr_i (rev_clr),
    .inc_i (rev_inc),
    .dec_i (rev_dec),
    .cnt_o (rev_o)
  );

  qdec_updown #(.W(DIFF_W)) u_diff (
    .clk   (clk),
    .rst   (rst),
    .clr_i (1'b0),
    .inc_i (cnt_go &  step.up),
    .dec_i (cnt_go & ~step.up),
    .cnt_o (diff_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q          <= 1'b1;
      ev_rollover_o  <= 1'b0;
      ev_rollunder_o <= 1'b0;
      ev_index_o     <= 1'b0;
      ev_home_o      <= 1'b0;
      ev_dirchg_o    <= 1'b0;
      ev_both_o      <= 1'b0;
    end else begin
      if (cnt_go) dir_q <= step.up;
      ev_rollover_o  <= ov_nx;
      ev_rollunder_o <= un_nx;
      ev_index_o     <= idx_edge;
      ev_home_o      <= cnt_mode_i ? home_chg : home_edge;
      ev_dirchg_o    <= cnt_go & (step.up != dir_q);
      ev_both_o      <= both_chg;
    end
  end

  assign dir_o = dir_q;

endmodule

// File: rtl/qdec_poscnt_chk.sv
module qdec_poscnt_chk #(
  parameter int POS_W  = 32,
  parameter int DIFF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [POS_W-1:0]  init_val_i,
  input logic [POS_W-1:0]  mod_val_i,
  input logic [POS_W-1:0]  pos_o,
  input logic [DIFF_W-1:0] diff_o,
  input logic              dir_o,
  input logic              ev_rollover_o,
  input logic              ev_rollunder_o,
  input logic              ev_dirchg_o
);

  assert_rollover_to_init_R4: assert property (@(posedge clk) disable iff (rst)
    ev_rollover_o |-> pos_o == init_val_i);

  assert_rollunder_to_mod_R4: assert property (@(posedge clk) disable iff (rst)
    ev_rollunder_o |-> pos_o == mod_val_i);

  assert_roll_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(ev_rollover_o && ev_rollunder_o));

  assert_dirchg_flips_R5: assert property (@(posedge clk) disable iff (rst)
    ev_dirchg_o |-> dir_o != $past(dir_o));

  assert_rollover_up_R5: assert property (@(posedge clk) disable iff (rst)
    ev_rollover_o |-> dir_o);

  assert_rollunder_down_R5: assert property (@(posedge clk) disable iff (rst)
    ev_rollunder_o |-> !dir_o);

  assert_diff_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (diff_o == $past(diff_o)) || (diff_o == $past(diff_o) + 1'b1) || (diff_o == $past(diff_o) - 1'b1));

endmodule

bind qdec_poscnt qdec_poscnt_chk #(.POS_W(POS_W), .DIFF_W(DIFF_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .init_val_i     (init_val_i),
  .mod_val_i      (mod_val_i),
  .pos_o          (pos_o),
  .diff_o         (diff_o),
  .dir_o          (dir_o),
  .ev_rollover_o  (ev_rollover_o),
  .ev_rollunder_o (ev_rollunder_o),
  .ev_dirchg_o    (ev_dirchg_o)
);

// File: tb/qdec_poscnt_bench.sv
module qdec_poscnt_bench;

  localparam logic [5:0] EV0 = 6'b000000;
  localparam logic [5:0] RO  = 6'b000001;
  localparam logic [5:0] RU  = 6'b000010;
  localparam logic [5:0] IX  = 6'b000100;
  localparam logic [5:0] HM  = 6'b001000;
  localparam logic [5:0] DC  = 6'b010000;
  localparam logic [5:0] AB  = 6'b100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pha = 0, phb = 0, idx = 0, home = 0, sw = 0;
  logic cnt_mode = 0, idx_neg = 0, home_neg = 0, idx_init_en = 1, home_init_en = 0;
  logic reverse = 0, single_ph = 0, one_shot = 0, rev_on_wrap = 0;
  logic [31:0] init_val = 32'd10;
  logic [31:0] mod_val  = 32'd13;
  logic [31:0] pos;
  logic [15:0] rev, diff;
  logic dir, e_ro, e_ru, e_ix, e_hm, e_dc, e_ab;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  typedef struct {
    int          due;
    logic [31:0] pos;
    logic [15:0] rev;
    logic [15:0] diff;
    logic        dir;
    logic [5:0]  ev;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  qdec_poscnt u_qdec_poscnt (
    .clk(clk), .rst(rst), .pha_i(pha), .phb_i(phb), .idx_i(idx), .home_i(home),
    .swinit_i(sw), .cnt_mode_i(cnt_mode), .idx_neg_i(idx_neg), .home_neg_i(home_neg),
    .idx_init_en_i(idx_init_en), .home_init_en_i(home_init_en), .reverse_i(reverse),
    .single_ph_i(single_ph), .one_shot_i(one_shot), .rev_on_wrap_i(rev_on_wrap),
    .init_val_i(init_val), .mod_val_i(mod_val), .pos_o(pos), .rev_o(rev), .diff_o(diff),
    .dir_o(dir), .ev_rollover_o(e_ro), .ev_rollunder_o(e_ru), .ev_index_o(e_ix),
    .ev_home_o(e_hm), .ev_dirchg_o(e_dc), .ev_both_o(e_ab)
  );

  function automatic logic [5:0] ev_now();
    return {e_ab, e_dc, e_hm, e_ix, e_ru, e_ro};
  endfunction

  task automatic compare(input exp_t x);
    vectors++;
    if (pos !== x.pos || rev !== x.rev || diff !== x.diff || dir !== x.dir || ev_now() !== x.ev) begin
      fails++;
      $display("FAIL %s: pos=%0d rev=%0d diff=%0d dir=%0b ev=%06b expected pos=%0d rev=%0d diff=%0d dir=%0b ev=%06b",
               x.tag, pos, rev, diff, dir, ev_now(), x.pos, x.rev, x.diff, x.dir, x.ev);
    end
  endtask

  // Monitor: results are due two clock edges after the drive.
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) compare(sbq.pop_front());
  end

  // Driver: apply inputs and push the expected result.
  task automatic apply(input logic a, input logic b, input logic ix, input logic hm, input logic s,
                       input int p, input int r, input int d, input logic dr,
                       input logic [5:0] ev, input string tag);
    exp_t x;
    @(negedge clk);
    pha = a; phb = b; idx = ix; home = hm; sw = s;
    x.due = cyc + 2; x.pos = p; x.rev = r[15:0]; x.diff = d[15:0];
    x.dir = dr; x.ev = ev; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    exp_t r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    r0.due = 0; r0.pos = 0; r0.rev = 0; r0.diff = 0; r0.dir = 1; r0.ev = EV0; r0.tag = "R1 reset";
    compare(r0);

    apply(0,0,0,0,1, 10,0,0,1, EV0, "R6 sw reload");
    apply(0,0,0,0,0, 10,0,0,1, EV0, "R6 sw released");
    apply(1,0,0,0,0, 11,0,1,1, EV0, "R2 up 00-10");
    apply(1,1,0,0,0, 12,0,2,1, EV0, "R2 up 10-11");
    apply(0,1,0,0,0, 13,0,3,1, EV0, "R2 up 11-01");
    apply(0,0,0,0,0, 10,0,4,1, RO,  "R4 roll-over");
    apply(0,1,0,0,0, 13,0,3,0, RU|DC, "R4 R5 roll-under");
    apply(1,1,0,0,0, 12,0,2,0, EV0, "R2 down 01-11");
    apply(0,0,0,0,0, 12,0,2,0, AB,  "R3 both phases");
    apply(1,0,0,0,0, 13,0,3,1, DC,  "R5 direction change");
    apply(1,0,1,0,0, 10,1,3,1, IX,  "R6 R10 index reload");
    apply(1,0,0,0,0, 10,1,3,1, EV0, "R7 falling index ignored");
    settle(); idx_neg = 1;
    apply(1,1,0,0,0, 11,1,4,1, EV0, "R2 up");
    apply(1,1,1,0,0, 11,1,4,1, EV0, "R7 rising index ignored");
    apply(1,1,0,0,0, 10,2,4,1, IX,  "R7 falling index active");
    settle(); idx_neg = 0; idx_init_en = 0; home_init_en = 1;
    apply(0,1,0,0,0, 11,2,5,1, EV0, "R2 up");
    apply(0,1,0,1,0, 10,2,5,1, HM,  "R6 home reload");
    apply(0,1,0,0,0, 10,2,5,1, EV0, "R6 home falling ignored");
    apply(0,0,0,0,0, 11,2,6,1, EV0, "R2 up");
    apply(0,0,1,0,0, 11,3,6,1, IX,  "R10 index counts, reload disabled R6");
    apply(0,0,0,0,0, 11,3,6,1, EV0, "R7 index low");
    settle(); reverse = 1;
    apply(0,0,0,0,1, 13,3,6,1, EV0, "R6 R8 reload from modulus");
    apply(0,0,0,0,0, 13,3,6,1, EV0, "R8 sw released");
    apply(1,0,0,0,0, 12,3,5,0, DC,  "R8 reversed count");
    settle(); reverse = 0; one_shot = 1; rev_on_wrap = 1;
    apply(1,1,0,0,0, 13,3,6,1, DC,  "R9 up");
    apply(0,1,0,0,0, 10,4,7,1, RO,  "R9 R10 wrap steps rev");
    apply(0,0,0,0,0, 10,4,8,1, EV0, "R9 stopped after wrap");
    apply(0,0,0,0,1, 10,4,8,1, EV0, "R9 reload");
    apply(0,0,0,0,0, 10,4,8,1, EV0, "R9 sw released");
    apply(1,0,0,0,0, 11,4,9,1, EV0, "R9 resumed");
    apply(0,0,0,0,0, 10,4,8,0, DC,  "R9 down");
    apply(0,1,0,0,0, 13,3,7,0, RU,  "R10 roll-under steps rev down");
    settle(); one_shot = 0; rev_on_wrap = 0; cnt_mode = 1;
    apply(1,1,0,0,0, 13,3,7,0, EV0, "R11 gated while enable low");
    apply(1,1,0,1,0, 13,3,7,0, HM,  "R11 enable change event");
    apply(1,0,0,1,0, 12,3,6,0, EV0, "R11 counts while enabled");
    apply(1,0,1,1,0, 10,0,6,0, IX,  "R12 preset");
    apply(1,0,0,1,0, 10,0,6,0, EV0, "R12 preset low");
    settle(); home_neg = 1;
    apply(0,0,0,1,0, 10,0,6,0, EV0, "R11 active-low enable gates");
    apply(0,0,0,0,0, 10,0,6,0, HM,  "R11 enable change event");
    apply(0,1,0,0,0, 13,0,5,0, RU,  "R11 counts active-low");
    settle(); cnt_mode = 0; single_ph = 1; home_neg = 0;
    apply(1,1,0,0,0, 12,0,4,0, EV0, "R13 A rise B high down");
    apply(0,1,0,0,0, 12,0,4,0, EV0, "R13 A fall ignored");
    apply(0,0,0,0,0, 12,0,4,0, EV0, "R13 B change ignored");
    apply(1,0,0,0,0, 13,0,5,1, DC,  "R13 A rise B low up");
    apply(0,0,0,0,0, 13,0,5,1, EV0, "R13 A fall ignored");
    apply(1,0,0,0,0, 10,0,6,1, RO,  "R13 R4 single-phase wrap");
    settle();
    vectors++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R2 scoreboard: actual=%0d pending expected=0", sbq.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule